// File: doc/BRIEF.md
# I2C Master Byte-Counted Read Engine

This block is a two-wire (I2C) bus master that performs read transfers only. Software presents a 7-bit target address and a byte count, then pulses a start command. The engine issues a START condition and sends the address with the direction bit set to read. It checks the target's acknowledge and then clocks in the programmed number of data bytes. Each completed byte lands in a one-entry holding register and raises a receive-ready flag. A DMA receive channel or the CPU uses that flag as its request to drain the register.

A down-counter of remaining bytes decides the master's acknowledge. Every byte is acknowledged except the final one. The final byte is answered with NACK, and the engine then generates STOP and reports completion without further software action. If the holding register is still occupied when another byte finishes, the engine keeps SCL low until the register is read, so no data is lost. An address that is not acknowledged ends the transfer with an error flag, a STOP and completion, and no data is received.

Bit timing comes from two programmable phase lengths counted in system clocks. Both wires are open-drain: the outputs only pull a line low or release it.

Top module: `i2c_read_engine`

## Requirements
- R1: After reset both bus lines are released, and `rx_ready_o`, `busy_o`, `done_o` and `addr_nack_o` are 0.
- R2: A start command accepted from idle produces a START (SDA falls while SCL is high). It is followed by the 7-bit address MSB first and then a 1 read bit, so address 0x5A puts the byte 0xB5 on the bus.
- R3: Each SCL low phase lasts `scl_low_cycles_i` clocks and each high phase lasts `scl_high_cycles_i` clocks. A setting below 2 counts as 2. The low phase that ends a data byte lasts one extra clock. SDA changes while SCL is high only for START and STOP.
- R4: Data bits are sampled MSB first while SCL is high. Each full byte is placed on `rx_data_o` and `rx_ready_o` is set.
- R5: The master drives ACK (SDA low) in the ninth clock of every data byte except the last one of the count. After the last byte it leaves SDA released (NACK).
- R6: After the final NACK the engine sends STOP (SDA rises while SCL is high), then sets `done_o` and clears `busy_o`. `done_o` and `addr_nack_o` keep their value until the next accepted start, which clears both.
- R7: With a count of 1, the only byte is answered with NACK and is followed directly by STOP.
- R8: A one-cycle `rd_i` pulse clears `rx_ready_o`. While an unread byte is held, the next completed byte keeps SCL low and does not replace `rx_data_o` until it has been read.
- R9: If the address is not acknowledged, `addr_nack_o` is set, STOP is sent, `done_o` is set, and `rx_ready_o` never rises during that transfer.
- R10: A start command while `busy_o` is 1 is ignored. The running transfer keeps its address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a read transfer |
| slave_addr_i | input | 7 | Target address, sampled at an accepted start |
| byte_count_i | input | CNT_W | Number of data bytes to read, sampled at an accepted start |
| scl_low_cycles_i | input | DIV_W | Length of the SCL low phase in clocks |
| scl_high_cycles_i | input | DIV_W | Length of the SCL high phase in clocks |
| sda_i | input | 1 | Sensed level of the SDA line |
| rd_i | input | 1 | One-cycle read strobe for the holding register |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_data_o | output | 8 | Holding register contents |
| rx_ready_o | output | 1 | Holding register contains an unread byte |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | Last transfer finished with STOP |
| addr_nack_o | output | 1 | Last transfer's address was not acknowledged |

## Verification
The engine is exercised with a three-byte read using prompt draining, a single-byte read, and a read with phase settings below the minimum. These patterns separate correct ACK/NACK steering by the byte counter from an off-by-one in the count, and they show whether the clamp on phase lengths applies. A read whose first byte is deliberately left unread shows the difference between stalling SCL and overwriting data. An address rejected by the target shows that the error path skips all data. A second start issued mid-transfer shows that a busy engine keeps its first address and count.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_START = 4'd1,
        ST_ADDR  = 4'd2,
        ST_AACK  = 4'd3,
        ST_DATA  = 4'd4,
        ST_HOLD  = 4'd5,
        ST_MACK  = 4'd6,
        ST_STOP  = 4'd7,
        ST_FREE  = 4'd8
    } state_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // shortest SCL phase: one clock to move SDA, one to let it settle
    localparam int MIN_PHASE = 2;

endpackage

// File: rtl/i2crd_timer.sv
module i2crd_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R3: the engine never asks for a phase shorter than the minimum
    assert_load_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> (load_val_i != '0));

    // R3: a freshly loaded phase cannot end on the next clock
    assert_phase_not_short_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !expired_o);

endmodule

// File: rtl/i2crd_rxhold.sv
module i2crd_rxhold #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rd_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         full;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (wr_i) begin
            hold_d.data = wdata_i;
            hold_d.full = 1'b1;
        end else if (rd_i) begin
            hold_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign data_o = hold_q.data;
    assign full_o = hold_q.full;

    // R8: an unread byte is never replaced
    assert_no_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |-> !hold_q.full);

endmodule

// File: rtl/i2c_read_engine.sv
module i2c_read_engine
    import i2crd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [6:0]       slave_addr_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [DIV_W-1:0] scl_low_cycles_i,
    input  logic [DIV_W-1:0] scl_high_cycles_i,
    input  logic             sda_i,
    input  logic             rd_i,
    output logic             scl_drive_low_o,
    output logic             sda_drive_low_o,
    output logic [7:0]       rx_data_o,
    output logic             rx_ready_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             addr_nack_o
);

    localparam logic [DIV_W-1:0] MIN_SPAN = DIV_W'(MIN_PHASE);
    localparam logic [DIV_W-1:0] MIN_LOAD = DIV_W'(MIN_PHASE - 1);

    typedef struct packed {
        state_e           state;
        phase_e           phase;
        logic             fresh;
        logic [2:0]       bitcnt;
        logic [7:0]       shreg;
        logic [CNT_W-1:0] left;
        logic             ackbit;
        logic             scl_low;
        logic             sda_low;
        logic             done;
        logic             anack;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [DIV_W-1:0] lo_load, hi_load, tmr_val;
    logic             tmr_load, tmr_exp;
    logic             rx_wr;
    logic             slot_bit;

    // phase counter reloads with length-1, clamped to the minimum
    assign lo_load = (scl_low_cycles_i < MIN_SPAN) ? MIN_LOAD : scl_low_cycles_i - DIV_W'(1);
    assign hi_load = (scl_high_cycles_i < MIN_SPAN) ? MIN_LOAD : scl_high_cycles_i - DIV_W'(1);

    i2crd_timer #(.W(DIV_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    i2crd_rxhold #(.W(8)) u_rxhold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (rx_wr),
        .wdata_i (regs_q.shreg),
        .rd_i    (rd_i),
        .data_o  (rx_data_o),
        .full_o  (rx_ready_o)
    );

    // level to pull onto SDA during the low phase of the current slot
    always_comb begin
        case (regs_q.state)
            ST_ADDR: slot_bit = ~regs_q.shreg[7];
            ST_MACK: slot_bit = (regs_q.left != '0);
            ST_STOP: slot_bit = 1'b1;
            default: slot_bit = 1'b0;
        endcase
    end

    always_comb begin
        regs_d   = regs_q;
        tmr_load = 1'b0;
        tmr_val  = hi_load;
        rx_wr    = 1'b0;
        case (regs_q.state)
            ST_IDLE: begin
                regs_d.scl_low = 1'b0;
                regs_d.sda_low = 1'b0;
                if (start_i) begin
                    regs_d.state   = ST_START;
                    regs_d.phase   = PH_HIGH;
                    regs_d.sda_low = 1'b1;
                    regs_d.shreg   = {slave_addr_i, 1'b1};
                    regs_d.left    = byte_count_i;
                    regs_d.bitcnt  = 3'd7;
                    regs_d.done    = 1'b0;
                    regs_d.anack   = 1'b0;
                    tmr_load       = 1'b1;
                    tmr_val        = hi_load;
                end
            end
            ST_START: begin
                if (tmr_exp) begin
                    regs_d.state   = ST_ADDR;
                    regs_d.scl_low = 1'b1;
                    regs_d.phase   = PH_LOW;
                    regs_d.fresh   = 1'b1;
                    tmr_load       = 1'b1;
                    tmr_val        = lo_load;
                end
            end
            ST_HOLD: begin
                if (!rx_ready_o) begin
                    rx_wr        = 1'b1;
                    regs_d.left  = regs_q.left - CNT_W'(1);
                    regs_d.state = ST_MACK;
                    regs_d.phase = PH_LOW;
                    regs_d.fresh = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = lo_load;
                end
            end
            ST_FREE: begin
                if (tmr_exp) begin
                    regs_d.state = ST_IDLE;
                    regs_d.done  = 1'b1;
                end
            end
            default: begin
                if (regs_q.phase == PH_LOW) begin
                    if (regs_q.fresh) begin
                        regs_d.fresh   = 1'b0;
                        regs_d.sda_low = slot_bit;
                    end else if (tmr_exp) begin
                        regs_d.scl_low = 1'b0;
                        regs_d.phase   = PH_HIGH;
                        regs_d.fresh   = 1'b1;
                        tmr_load       = 1'b1;
                        tmr_val        = hi_load;
                    end
                end else if (regs_q.fresh) begin
                    regs_d.fresh = 1'b0;
                    if (regs_q.state == ST_AACK) begin
                        regs_d.ackbit = sda_i;
                    end else if (regs_q.state == ST_DATA) begin
                        regs_d.shreg = {regs_q.shreg[6:0], sda_i};
                    end
                end else if (tmr_exp) begin
                    if (regs_q.state == ST_STOP) begin
                        regs_d.sda_low = 1'b0;
                        regs_d.state   = ST_FREE;
                        tmr_load       = 1'b1;
                        tmr_val        = hi_load;
                    end else begin
                        regs_d.scl_low = 1'b1;
                        regs_d.phase   = PH_LOW;
                        regs_d.fresh   = 1'b1;
                        tmr_load       = 1'b1;
                        tmr_val        = lo_load;
                        case (regs_q.state)
                            ST_ADDR: begin
                                if (regs_q.bitcnt == 3'd0) begin
                                    regs_d.state = ST_AACK;
                                end else begin
                                    regs_d.bitcnt = regs_q.bitcnt - 3'd1;
                                    regs_d.shreg  = {regs_q.shreg[6:0], 1'b0};
                                end
                            end
                            ST_AACK: begin
                                if (regs_q.ackbit) begin
                                    regs_d.anack = 1'b1;
                                    regs_d.state = ST_STOP;
                                end else if (regs_q.left == '0) begin
                                    regs_d.state = ST_STOP;
                                end else begin
                                    regs_d.state  = ST_DATA;
                                    regs_d.bitcnt = 3'd7;
                                end
                            end
                            ST_DATA: begin
                                if (regs_q.bitcnt == 3'd0) begin
                                    regs_d.state = ST_HOLD;
                                    regs_d.fresh = 1'b0;
                                    tmr_load     = 1'b0;
                                end else begin
                                    regs_d.bitcnt = regs_q.bitcnt - 3'd1;
                                end
                            end
                            default: begin
                                if (regs_q.left == '0) begin
                                    regs_d.state = ST_STOP;
                                end else begin
                                    regs_d.state  = ST_DATA;
                                    regs_d.bitcnt = 3'd7;
                                end
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign scl_drive_low_o = regs_q.scl_low;
    assign sda_drive_low_o = regs_q.sda_low;
    assign busy_o          = (regs_q.state != ST_IDLE);
    assign done_o          = regs_q.done;
    assign addr_nack_o     = regs_q.anack;

    // R3: inside bit slots SDA only moves while SCL is pulled low
    assert_sda_quiet_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((regs_q.state inside {ST_ADDR, ST_AACK, ST_DATA, ST_MACK}) &&
         !scl_drive_low_o && $past(!scl_drive_low_o)) |-> $stable(sda_drive_low_o));

    // R10: a busy engine never restarts
    assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> (regs_q.state != ST_START));

    // R6: completion is only reported with both lines released
    assert_done_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (!scl_drive_low_o && !sda_drive_low_o && !busy_o));

    // R9: a rejected address delivers no data
    assert_nack_no_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_nack_o |-> !rx_wr);

    // R8: while a finished byte waits for room, SCL stays low
    assert_stall_holds_scl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.state == ST_HOLD) |-> scl_drive_low_o);

endmodule

// File: tb/tb_i2c_read_engine.sv
module tb_i2c_read_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] addr = 7'h00;
    logic [7:0] count = 8'd0;
    logic [7:0] lo_cyc = 8'd4;
    logic [7:0] hi_cyc = 8'd3;
    logic       rd = 1'b0;
    logic       scl_dl, sda_dl;
    logic [7:0] rx_data;
    logic       rx_ready, busy, done, anack;
    logic       s_drive = 1'b0;

    wire scl = ~scl_dl;
    wire sda = ~(sda_dl | s_drive);

    always #5 clk = ~clk;

    i2c_read_engine #(.CNT_W(8), .DIV_W(8)) dut (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .start_i           (start),
        .slave_addr_i      (addr),
        .byte_count_i      (count),
        .scl_low_cycles_i  (lo_cyc),
        .scl_high_cycles_i (hi_cyc),
        .sda_i             (sda),
        .rd_i              (rd),
        .scl_drive_low_o   (scl_dl),
        .sda_drive_low_o   (sda_dl),
        .rx_data_o         (rx_data),
        .rx_ready_o        (rx_ready),
        .busy_o            (busy),
        .done_o            (done),
        .addr_nack_o       (anack)
    );

    int n_chk = 0;
    int n_bad = 0;

    // stimulus side (written only by initial/tasks)
    logic [7:0] tx_mem [8];
    logic [7:0] rx_buf [8];
    int         n_rx = 0;
    logic       ack_en = 1'b1;
    int         epoch = 0;
    int         exp_lo = 4;
    int         exp_hi = 3;
    logic       chk_timing = 1'b1;

    // monitor / target model side (written only by the monitor)
    int         seen_epoch = 0;
    int         n_starts = 0, n_stops = 0, n_acks = 0, tx_idx = 0;
    int         hi_bad = 0, lo_bad = 0, sda_hi_moves = 0, run_len = 0;
    logic [7:0] addr_seen = 8'h00;
    logic [7:0] sh = 8'h00;
    logic       ack_log [16];
    logic       last_ack = 1'b1;
    logic       in_xfer = 1'b0;
    int         mode = 0;
    int         sbits = 0;
    logic       pscl = 1'b1, psda = 1'b1;

    always @(negedge clk) begin
        if (seen_epoch != epoch) begin
            seen_epoch = epoch;
            n_starts = 0; n_stops = 0; n_acks = 0; tx_idx = 0;
            hi_bad = 0; lo_bad = 0; sda_hi_moves = 0;
            addr_seen = 8'h00;
        end
        if (rst_n) begin
            if (scl == pscl) begin
                run_len++;
            end else begin
                if (in_xfer && chk_timing) begin
                    if (pscl && run_len != exp_hi) hi_bad++;
                    if (!pscl && run_len != exp_lo && run_len != exp_lo + 1) lo_bad++;
                end
                if (pscl) in_xfer = 1'b1;
                run_len = 1;
            end
            if (scl && pscl && sda != psda) sda_hi_moves++;
            if (scl && pscl && psda && !sda) begin
                n_starts++; mode = 1; sbits = 0; sh = 8'h00; s_drive = 1'b0;
            end else if (scl && pscl && !psda && sda) begin
                n_stops++; mode = 0; s_drive = 1'b0; in_xfer = 1'b0;
            end else if (!pscl && scl) begin
                if (mode == 1) begin
                    sh = {sh[6:0], sda}; sbits++;
                end else if (mode == 4) begin
                    if (n_acks < 16) ack_log[n_acks] = sda;
                    n_acks++; last_ack = sda;
                end
            end else if (pscl && !scl) begin
                if (mode == 1 && sbits == 8) begin
                    addr_seen = sh;
                    if (ack_en) begin s_drive = 1'b1; mode = 2; end
                    else mode = 5;
                end else if (mode == 2) begin
                    s_drive = ~tx_mem[tx_idx][7]; sbits = 1; mode = 3;
                end else if (mode == 3) begin
                    if (sbits == 8) begin
                        s_drive = 1'b0; mode = 4; tx_idx++;
                    end else begin
                        s_drive = ~tx_mem[tx_idx][7-sbits]; sbits++;
                    end
                end else if (mode == 4) begin
                    if (!last_ack) begin
                        s_drive = ~tx_mem[tx_idx][7]; sbits = 1; mode = 3;
                    end else begin
                        s_drive = 1'b0; mode = 5;
                    end
                end
            end
            pscl = scl;
            psda = sda;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic new_epoch(input int lo, input int hi);
        lo_cyc = 8'(lo);
        hi_cyc = 8'(hi);
        exp_lo = (lo < 2) ? 2 : lo;
        exp_hi = (hi < 2) ? 2 : hi;
        chk_timing = 1'b1;
        n_rx = 0;
        epoch++;
        @(negedge clk);
    endtask

    task automatic kick(input logic [6:0] a, input int cnt);
        addr  = a;
        count = 8'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic collect(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done && !busy) break;
            if (rx_ready) begin
                if (n_rx < 8) rx_buf[n_rx] = rx_data;
                n_rx++;
                rd = 1'b1;
                @(negedge clk);
                rd = 1'b0;
                check("R8", "rx_ready after read", int'(rx_ready), 0);
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "scl released", int'(scl), 1);
        check("R1", "sda released", int'(sda), 1);
        check("R1", "rx_ready", int'(rx_ready), 0);
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "addr_nack", int'(anack), 0);
    endtask

    task automatic test_three_bytes();
        tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C; tx_mem[2] = 8'hF0;
        ack_en = 1'b1;
        new_epoch(4, 3);
        kick(7'h5A, 3);
        collect(5000);
        check("R2", "START count", n_starts, 1);
        check("R2", "address byte", int'(addr_seen), 8'hB5);
        check("R4", "bytes received", n_rx, 3);
        check("R4", "byte 0", int'(rx_buf[0]), 8'hA5);
        check("R4", "byte 1", int'(rx_buf[1]), 8'h3C);
        check("R4", "byte 2", int'(rx_buf[2]), 8'hF0);
        check("R5", "ack slots", n_acks, 3);
        check("R5", "ack byte 0", int'(ack_log[0]), 0);
        check("R5", "ack byte 1", int'(ack_log[1]), 0);
        check("R5", "nack last", int'(ack_log[2]), 1);
        check("R6", "STOP count", n_stops, 1);
        check("R6", "done", int'(done), 1);
        check("R6", "busy", int'(busy), 0);
        check("R3", "high phase errors", hi_bad, 0);
        check("R3", "low phase errors", lo_bad, 0);
        check("R3", "SDA moves with SCL high", sda_hi_moves, 2);
        repeat (40) @(negedge clk);
        check("R6", "done held", int'(done), 1);
    endtask

    task automatic test_single();
        tx_mem[0] = 8'h81;
        new_epoch(5, 4);
        kick(7'h21, 1);
        check("R6", "done cleared by start", int'(done), 0);
        check("R6", "busy after start", int'(busy), 1);
        collect(5000);
        check("R7", "one byte", n_rx, 1);
        check("R7", "byte value", int'(rx_buf[0]), 8'h81);
        check("R7", "single ack slot", n_acks, 1);
        check("R7", "nack on only byte", int'(ack_log[0]), 1);
        check("R7", "STOP", n_stops, 1);
        check("R3", "high phase errors", hi_bad, 0);
        check("R3", "low phase errors", lo_bad, 0);
    endtask

    task automatic test_clamp();
        tx_mem[0] = 8'h5E; tx_mem[1] = 8'h07;
        new_epoch(0, 1);
        kick(7'h33, 2);
        collect(5000);
        check("R3", "clamped high phases", hi_bad, 0);
        check("R3", "clamped low phases", lo_bad, 0);
        check("R4", "clamp byte 0", int'(rx_buf[0]), 8'h5E);
        check("R4", "clamp byte 1", int'(rx_buf[1]), 8'h07);
    endtask

    task automatic test_stall();
        int hi_seen;
        tx_mem[0] = 8'h11; tx_mem[1] = 8'h22; tx_mem[2] = 8'h33;
        new_epoch(4, 3);
        chk_timing = 1'b0;
        kick(7'h0F, 3);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rx_ready) break;
        end
        repeat (600) @(negedge clk);
        hi_seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (scl) hi_seen++;
        end
        check("R8", "SCL held low while full", hi_seen, 0);
        check("R8", "first byte kept", int'(rx_data), 8'h11);
        check("R8", "still ready", int'(rx_ready), 1);
        rx_buf[0] = rx_data;
        n_rx = 1;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R8", "ready cleared by read", int'(rx_ready), 0);
        collect(5000);
        check("R8", "bytes after stall", n_rx, 3);
        check("R8", "stalled byte 1", int'(rx_buf[1]), 8'h22);
        check("R8", "stalled byte 2", int'(rx_buf[2]), 8'h33);
        check("R6", "STOP after stall", n_stops, 1);
    endtask

    task automatic test_addr_nack();
        int ready_seen;
        ack_en = 1'b0;
        new_epoch(4, 3);
        kick(7'h44, 2);
        ready_seen = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (rx_ready) ready_seen++;
            if (done && !busy) break;
        end
        check("R9", "addr_nack", int'(anack), 1);
        check("R9", "done", int'(done), 1);
        check("R9", "no data", ready_seen, 0);
        check("R9", "STOP", n_stops, 1);
        check("R9", "no data ack slots", n_acks, 0);
        ack_en = 1'b1;
    endtask

    task automatic test_busy_start();
        tx_mem[0] = 8'h9C; tx_mem[1] = 8'h42;
        new_epoch(4, 3);
        kick(7'h5A, 2);
        check("R6", "addr_nack cleared by start", int'(anack), 0);
        repeat (30) @(negedge clk);
        kick(7'h11, 5);
        collect(5000);
        check("R10", "single START", n_starts, 1);
        check("R10", "first address kept", int'(addr_seen), 8'hB5);
        check("R10", "first count kept", n_rx, 2);
        check("R10", "byte 0", int'(rx_buf[0]), 8'h9C);
        check("R10", "byte 1", int'(rx_buf[1]), 8'h42);
    endtask

    initial begin
        test_reset();
        test_three_bytes();
        test_single();
        test_clamp();
        test_stall();
        test_addr_nack();
        test_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule